// File: doc/BRIEF.md
# Zero-Hardwired Three-Port Register File

This block is the general-purpose register file of a small 32-bit load/store processor. It holds 32 words of 32 bits. There are two independent read ports, so one instruction can fetch both of its source operands in the same cycle. There is one write port, which stores the instruction's result. The two reads are combinational from their 5-bit indices. The write takes effect on the rising clock edge while the write enable is high.

Index 0 is not storage. It always reads as zero, and any write aimed at it is dropped. Software can therefore copy a register by adding it to index 0, or load a constant by adding an immediate to it. An active-low asynchronous reset clears every other entry.

A build parameter selects forwarding. When forwarding is on, a read of the nonzero index that is being written in the same cycle returns the incoming write data instead of the stored word. When forwarding is off, that read returns the stored word and the new value is visible only from the next cycle on.

Top module: `gpr_file`

## Requirements
- R1: While `wr_en_i` is high at a rising edge of `clk_i` and `wr_addr_i` is nonzero, the entry at `wr_addr_i` takes `wr_data_i`. After that edge, reading that index returns the new word.
- R2: Reading index 0 on either port returns 32'h0000_0000 in every cycle, whatever was written to index 0 before.
- R3: A write with `wr_addr_i` = 0 changes no entry. Index 0 still reads zero and every other index keeps its value.
- R4: While `wr_en_i` is low, no entry changes, whatever `wr_addr_i` and `wr_data_i` hold.
- R5: The two read ports are independent and combinational. In the same cycle, each port returns the entry selected by its own index.
- R6: While `rst_ni` is low, all 32 entries read as zero. This holds both after power-up and after a reset in the middle of operation.
- R7: With `BYPASS`=1, a read port whose index equals a nonzero `wr_addr_i` returns `wr_data_i` in the cycle before the write edge, while `wr_en_i` is high. A write to index 0 is never forwarded.
- R8: With `BYPASS`=0, a read port in the same situation returns the stored (old) word until the write edge.
- R9: A write to one index leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes occur on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears all entries |
| ra_addr_i | input | 5 | Index read by port A |
| ra_data_o | output | 32 | Word read by port A |
| rb_addr_i | input | 5 | Index read by port B |
| rb_data_o | output | 32 | Word read by port B |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Index to write |
| wr_data_i | input | 32 | Word to write |

## Verification
A read and a write of the same index can fall in the same cycle, and this is where forwarding and the zero entry interact. The bench drives a write and points one or both read ports at its index before the clock edge. It runs this against two instances, one with forwarding on and one with it off. In the cycle before the edge it judges that the forwarding instance shows the new word, that the other instance shows the stored word, and that neither forwards anything when the index is 0. It then runs random traffic, with many collisions and writes to index 0, against a reference array.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;
  localparam int unsigned GPR_DATA_W_DEF = 32;
  localparam int unsigned GPR_DEPTH_DEF  = 32;

  // A write is live only when enabled and not aimed at the zero entry.
  function automatic logic live_write(input logic en, input logic zero_idx);
    return en && !zero_idx;
  endfunction
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
  import gpr_file_pkg::*;
#(
  parameter int unsigned DEPTH  = GPR_DEPTH_DEF,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [DEPTH-1:0]  row_we_o
);

  always_comb begin
    row_we_o = '0;
    for (int i = 1; i < DEPTH; i++) begin
      row_we_o[i] = live_write(wr_en_i, wr_addr_i == '0) && (wr_addr_i == ADDR_W'(i));
    end
  end

  // R9
  one_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_we_o));

  // R3
  zero_row_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_i == '0) |-> (row_we_o == '0));

  // R4
  idle_no_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (row_we_o == '0));

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_file_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_DATA_W_DEF,
  parameter int unsigned DEPTH  = GPR_DEPTH_DEF,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DEPTH-1:0]             row_we_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [DEPTH-1:0][DATA_W-1:0] rows_o
);

  // Entry 0 is a constant: no flop, no reset needed.
  assign rows_o[0] = '0;

  for (genvar g = 1; g < DEPTH; g++) begin : g_row
    logic [DATA_W-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          row_q <= '0;
      else if (row_we_i[g]) row_q <= wr_data_i;
    end
    assign rows_o[g] = row_q;
  end

  // R1
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_we_i != '0) |=> (rows_o[$past(wr_addr_i)] == $past(wr_data_i)));

  // R4
  no_we_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_we_i == '0) |=> $stable(rows_o));

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_file_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_DATA_W_DEF,
  parameter int unsigned DEPTH  = GPR_DEPTH_DEF,
  parameter bit          BYPASS = 1'b1,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DEPTH-1:0][DATA_W-1:0] rows_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [DATA_W-1:0]            rd_data_o
);

  logic collide;
  assign collide = live_write(wr_en_i, wr_addr_i == '0) && (wr_addr_i == rd_addr_i);

  if (BYPASS) begin : g_fwd
    assign rd_data_o = collide ? wr_data_i : rows_i[rd_addr_i];

    // R7
    fwd_new_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      collide |-> (rd_data_o == wr_data_i));
  end else begin : g_nofwd
    assign rd_data_o = rows_i[rd_addr_i];

    // R8
    nofwd_old_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      collide |=> (rd_data_o == $past(wr_data_i)) || (rd_addr_i != $past(rd_addr_i))
                  || (wr_en_i && wr_addr_i == rd_addr_i));
  end

  // R2
  zero_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == '0) |-> (rd_data_o == '0));

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_file_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_DATA_W_DEF,
  parameter int unsigned DEPTH  = GPR_DEPTH_DEF,
  parameter bit          BYPASS = 1'b1,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);

  localparam int unsigned N_RD = 2;

  logic [DEPTH-1:0]             row_we;
  logic [DEPTH-1:0][DATA_W-1:0] rows;
  logic [N_RD-1:0][ADDR_W-1:0]  rd_addr;
  logic [N_RD-1:0][DATA_W-1:0]  rd_data;

  gpr_wr_decode #(.DEPTH(DEPTH)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .row_we_o  (row_we)
  );

  gpr_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .row_we_i  (row_we),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rows_o    (rows)
  );

  assign rd_addr[0] = ra_addr_i;
  assign rd_addr[1] = rb_addr_i;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    gpr_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BYPASS(BYPASS)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rows_i    (rows),
      .rd_addr_i (rd_addr[p]),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data[p])
    );
  end

  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];

  // R5
  same_idx_same_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == rb_addr_i) |-> (ra_data_o == rb_data_o));

  // R6
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (ra_data_o == '0) && (rb_data_o == '0));

endmodule

// File: tb/sim_gpr_file.sv
`timescale 1ns/1ps
module sim_gpr_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ra0, rb0, ra1, rb1;
  logic [31:0] ref_q [32];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpr_file #(.BYPASS(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ra_addr_i(ra_addr), .ra_data_o(ra0),
    .rb_addr_i(rb_addr), .rb_data_o(rb0), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data));

  gpr_file #(.BYPASS(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ra_addr_i(ra_addr), .ra_data_o(ra1),
    .rb_addr_i(rb_addr), .rb_data_o(rb1), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a != 0) ref_q[a] = d;
  endtask

  // Compare every index on both ports of both instances with the model.
  task automatic sweep(input string req);
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      ra_addr = 5'(i); rb_addr = 5'(31 - i); #1;
      check(req, ra0, ref_q[i]);
      check(req, rb0, ref_q[31 - i]);
      check(req, ra1, ref_q[i]);
      check(req, rb1, ref_q[31 - i]);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) ref_q[i] = '0;
    sweep("R6 power-up reset");
  endtask

  task automatic t_fill();
    for (int i = 1; i < 32; i++) write_word(5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101));
    sweep("R1 R5 R9 fill and read back");
  endtask

  task automatic t_zero_write();
    write_word(5'd0, 32'hFFFF_FFFF);
    sweep("R2 R3 write to zero dropped");
  endtask

  task automatic t_idle();
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd7; wr_data = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    sweep("R4 disabled write");
  endtask

  task automatic t_collide();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h1234_5678;
    ra_addr = 5'd5; rb_addr = 5'd6; #1;
    check("R7 forwarded word", ra0, 32'h1234_5678);
    check("R8 no forwarding", ra1, ref_q[5]);
    check("R5 other port", rb0, ref_q[6]);
    @(posedge clk); #1;
    wr_en = 1'b0; ref_q[5] = 32'h1234_5678;
    check("R8 new word after edge", ra1, 32'h1234_5678);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hCAFE_F00D;
    ra_addr = 5'd0; rb_addr = 5'd0; #1;
    check("R7 zero not forwarded", ra0, 32'h0);
    check("R2 zero port b", rb0, 32'h0);
    check("R2 zero nofwd", ra1, 32'h0);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R3 zero after edge", ra0, 32'h0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      logic [31:0] e0a, e0b;
      @(negedge clk);
      wr_en = ($urandom % 4) != 0;
      wr_addr = ($urandom % 5 == 0) ? 5'd0 : 5'($urandom);
      wr_data = $urandom;
      ra_addr = ($urandom % 3 == 0) ? wr_addr : 5'($urandom);
      rb_addr = ($urandom % 3 == 0) ? wr_addr : 5'($urandom);
      #1;
      e0a = (wr_en && wr_addr != 0 && ra_addr == wr_addr) ? wr_data : ref_q[ra_addr];
      e0b = (wr_en && wr_addr != 0 && rb_addr == wr_addr) ? wr_data : ref_q[rb_addr];
      check("R7 random fwd a", ra0, e0a);
      check("R7 random fwd b", rb0, e0b);
      check("R8 random a", ra1, ref_q[ra_addr]);
      check("R8 random b", rb1, ref_q[rb_addr]);
      @(posedge clk); #1;
      if (wr_en && wr_addr != 0) ref_q[wr_addr] = wr_data;
      wr_en = 1'b0;
    end
    sweep("R1 R3 R9 after random traffic");
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0; #1;
    for (int i = 0; i < 32; i++) ref_q[i] = '0;
    for (int i = 0; i < 32; i++) begin
      ra_addr = 5'(i); rb_addr = 5'(i); #1;
      check("R6 mid-run reset a", ra0, 32'h0);
      check("R6 mid-run reset b", rb1, 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R6 after reset release");
  endtask

  initial begin
    #200_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_fill();
    t_zero_write();
    t_idle();
    t_collide();
    t_random();
    t_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule